// File: doc/BRIEF.md
# Configuration Overlay Unlock Sequencer

This block sits on the write and read strobes of a memory port and watches for a three-write key sequence. Once the full key has been written, the whole address range of the port stops reaching the memory array and maps onto a small bank of configuration registers instead. That bank holds one protection control word and eight 32-bit password words. A single dedicated exit write returns the port to normal memory traffic. The register contents stay in place after the exit, and they drive the protection logic downstream.

In normal mode the block forwards reads and writes to the array through `mem_rd` and `mem_wr`. It holds back only the writes that form part of the key. In overlay mode nothing reaches the array. Register read data is combinational from the stored values, and register writes take effect at the clock edge.

Top module: `ovl_unlock_top`

## Requirements
- R1: Reset (`rst_n` low) clears the overlay flag, the key tracker, the control word and all password words. After reset, `ovl_active` is 0 and every configuration output is 0.
- R2: Three writes in a row make `ovl_active` rise one clock after the third write. The writes are: word data 0x000000AA to byte address 0x55, then 0x00000055 to 0x2AA, then 0x000000AA to 0x55. Address and data are compared over their full width.
- R3: A write that does not match the next expected key step drops the tracker back to its start. A later partial sequence then does not open the overlay.
- R4: While the tracker waits for step two, a write that repeats step one keeps the tracker waiting for step two. That write counts as a fresh step one.
- R5: Reads, in normal mode, leave the key tracker unchanged, even when they fall between key writes.
- R6: In normal mode, a write that advances or restarts the key is not forwarded (`mem_wr` low). Every other write is forwarded with `mem_wr` high in the same cycle.
- R7: While `ovl_active` is 1, `mem_wr` and `mem_rd` stay 0. Every access is served by the register bank, whose word index is the byte address divided by 4, with address bits [1:0] ignored.
- R8: Word index 0 is the control word. Bits [3:0] hold the read-protection range and bits [7:4] the write-protection range. Bit 8 is the read-protection enable and bit 9 the write-protection enable. Bits [31:10] read as 0 and ignore writes.
- R9: Word indices 1 to 8 hold password words 0 to 7. Password word k appears on `password[32k+31:32k]` and reads back exactly as written.
- R10: In overlay mode, word indices above 8 read as 0, and writes to them change no register.
- R11: In overlay mode, a write of data 0x000000FF to byte address 0x5A clears `ovl_active` one clock later and alters no register. Normal forwarding resumes from the next access, with register values retained.
- R12: In normal mode, the exit write is an ordinary forwarded write and does not change `ovl_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one access |
| bus_rd | input | 1 | Read strobe for one access |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| mem_wr | output | 1 | Write forwarded to the memory array |
| mem_rd | output | 1 | Read forwarded to the memory array |
| reg_rdata | output | DATA_W | Register bank read data (valid in overlay mode) |
| ovl_active | output | 1 | Overlay mode flag |
| rd_prot_range | output | 4 | Read-protection range field |
| wr_prot_range | output | 4 | Write-protection range field |
| rd_prot_en | output | 1 | Read-protection enable |
| wr_prot_en | output | 1 | Write-protection enable |
| password | output | PW_WORDS*DATA_W | Password words, word 0 in the low bits |

## Verification
The bench targets the key tracker's recovery paths:
- An aborted key followed by the remaining steps: a tracker that never resets would open the overlay.
- A repeated first step: a tracker that falls to idle would stay closed.
- Reads interleaved with key writes: a tracker that reacts to reads would lose its place.

For the register bank, the bench writes all ones into the control word to expose reserved bits that store data. It writes past the last password word to catch an index decode that wraps onto a real register. It checks that the exit write and an earlier overlay session leave the stored values intact. It also checks that the exit command outside the overlay goes through to memory as a normal write, rather than being swallowed.

// File: rtl/ovl_unlock_pkg.sv
package ovl_unlock_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_HAVE1 = 2'd1,
    SQ_HAVE2 = 2'd2
  } seq_state_e;

  // control word layout, LSB first: rd range, wr range, rd enable, wr enable
  typedef struct packed {
    logic       wr_en;
    logic       rd_en;
    logic [3:0] wr_range;
    logic [3:0] rd_range;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // exact compare of an access against one key step
  function automatic logic step_match(input logic [63:0] addr, input logic [63:0] data,
                                      input logic [63:0] key_a, input logic [63:0] key_d);
    return (addr == key_a) && (data == key_d);
  endfunction

  // word slot of a byte address; bits [1:0] ignored
  function automatic logic [63:0] word_slot(input logic [63:0] byte_addr);
    return byte_addr >> 2;
  endfunction

endpackage

// File: rtl/ovl_seq.sv
module ovl_seq
  import ovl_unlock_pkg::*;
#(
  parameter int          ADDR_W  = 32,
  parameter int          DATA_W  = 32,
  parameter int unsigned KEY_A1  = 32'h55,
  parameter int unsigned KEY_D1  = 32'hAA,
  parameter int unsigned KEY_A2  = 32'h2AA,
  parameter int unsigned KEY_D2  = 32'h55,
  parameter int unsigned EXIT_A  = 32'h5A,
  parameter int unsigned EXIT_D  = 32'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              active_o,
  output logic              seq_hit_o,
  output logic              exit_hit_o
);

  seq_state_e state_q, state_d;
  logic       active_q, active_d;
  logic       m1, m2, mx;

  always_comb begin
    m1 = step_match(64'(addr), 64'(wdata), 64'(KEY_A1), 64'(KEY_D1));
    m2 = step_match(64'(addr), 64'(wdata), 64'(KEY_A2), 64'(KEY_D2));
    mx = step_match(64'(addr), 64'(wdata), 64'(EXIT_A), 64'(EXIT_D));
  end

  always_comb begin
    state_d  = state_q;
    active_d = active_q;
    if (wr) begin
      if (active_q) begin
        if (mx) active_d = 1'b0;
        state_d = SQ_IDLE;
      end else begin
        unique case (state_q)
          SQ_IDLE:  state_d = m1 ? SQ_HAVE1 : SQ_IDLE;
          SQ_HAVE1: state_d = m2 ? SQ_HAVE2 : (m1 ? SQ_HAVE1 : SQ_IDLE);
          SQ_HAVE2: begin
            state_d = SQ_IDLE;
            if (m1) active_d = 1'b1;
          end
          default:  state_d = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      active_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      active_q <= active_d;
    end
  end

  assign active_o   = active_q;
  assign seq_hit_o  = wr && !active_q && (m1 || (state_q == SQ_HAVE1 && m2));
  assign exit_hit_o = wr && active_q && mx;

endmodule

// File: rtl/ovl_regfile.sv
module ovl_regfile
  import ovl_unlock_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PW_WORDS = 8,
  parameter int IDX_W    = $clog2(PW_WORDS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic                       idx_valid,
  input  logic [IDX_W-1:0]           idx,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output ctrl_t                      ctrl_o,
  output logic [PW_WORDS*DATA_W-1:0] pw_o
);

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] pw_q [PW_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             ctrl_q <= '0;
    else if (we && idx_valid && idx == '0)  ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
  end

  for (genvar k = 0; k < PW_WORDS; k++) begin : g_pw
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      pw_q[k] <= '0;
      else if (we && idx_valid && idx == IDX_W'(k + 1)) pw_q[k] <= wdata;
    end
    assign pw_o[k*DATA_W +: DATA_W] = pw_q[k];
  end

  always_comb begin
    rdata = '0;
    if (idx_valid) begin
      if (idx == '0) rdata = DATA_W'(ctrl_q);
      for (int k = 0; k < PW_WORDS; k++)
        if (idx == IDX_W'(k + 1)) rdata = pw_q[k];
    end
  end

  assign ctrl_o = ctrl_q;

endmodule

// File: rtl/ovl_unlock_top.sv
module ovl_unlock_top
  import ovl_unlock_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter int          PW_WORDS = 8,
  parameter int unsigned KEY_A1   = 32'h55,
  parameter int unsigned KEY_D1   = 32'hAA,
  parameter int unsigned KEY_A2   = 32'h2AA,
  parameter int unsigned KEY_D2   = 32'h55,
  parameter int unsigned EXIT_A   = 32'h5A,
  parameter int unsigned EXIT_D   = 32'hFF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic                       mem_wr,
  output logic                       mem_rd,
  output logic [DATA_W-1:0]          reg_rdata,
  output logic                       ovl_active,
  output logic [3:0]                 rd_prot_range,
  output logic [3:0]                 wr_prot_range,
  output logic                       rd_prot_en,
  output logic                       wr_prot_en,
  output logic [PW_WORDS*DATA_W-1:0] password
);

  localparam int IDX_W = $clog2(PW_WORDS + 1);

  // named internal events
  logic              seq_hit;
  logic              exit_hit;
  logic              reg_we;
  logic              idx_valid;
  logic [63:0]       slot;
  logic [IDX_W-1:0]  reg_idx;
  ctrl_t             ctrl;

  ovl_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KEY_A1(KEY_A1), .KEY_D1(KEY_D1), .KEY_A2(KEY_A2), .KEY_D2(KEY_D2),
    .EXIT_A(EXIT_A), .EXIT_D(EXIT_D)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (bus_wr),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .active_o   (ovl_active),
    .seq_hit_o  (seq_hit),
    .exit_hit_o (exit_hit)
  );

  assign slot      = word_slot(64'(bus_addr));
  assign idx_valid = (slot <= 64'(PW_WORDS));
  assign reg_idx   = slot[IDX_W-1:0];
  assign reg_we    = bus_wr && ovl_active && !exit_hit;

  ovl_regfile #(
    .DATA_W(DATA_W), .PW_WORDS(PW_WORDS), .IDX_W(IDX_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (reg_we),
    .idx_valid (idx_valid),
    .idx       (reg_idx),
    .wdata     (bus_wdata),
    .rdata     (reg_rdata),
    .ctrl_o    (ctrl),
    .pw_o      (password)
  );

  assign mem_wr        = bus_wr && !ovl_active && !seq_hit;
  assign mem_rd        = bus_rd && !ovl_active;
  assign rd_prot_range = ctrl.rd_range;
  assign wr_prot_range = ctrl.wr_range;
  assign rd_prot_en    = ctrl.rd_en;
  assign wr_prot_en    = ctrl.wr_en;

endmodule

// File: rtl/ovl_unlock_chk.sv
module ovl_unlock_chk #(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter int          PW_WORDS = 8,
  parameter int unsigned KEY_A1   = 32'h55,
  parameter int unsigned KEY_D1   = 32'hAA,
  parameter int unsigned EXIT_A   = 32'h5A,
  parameter int unsigned EXIT_D   = 32'hFF
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_wr,
  input logic                       bus_rd,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [DATA_W-1:0]          bus_wdata,
  input logic                       mem_wr,
  input logic                       mem_rd,
  input logic [DATA_W-1:0]          reg_rdata,
  input logic                       ovl_active,
  input logic [3:0]                 rd_prot_range,
  input logic [3:0]                 wr_prot_range,
  input logic                       rd_prot_en,
  input logic                       wr_prot_en,
  input logic [PW_WORDS*DATA_W-1:0] password
);

  logic [9:0] ctrl_view;
  assign ctrl_view = {wr_prot_en, rd_prot_en, wr_prot_range, rd_prot_range};

  // R7
  overlay_blocks_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_active |-> !(mem_wr || mem_rd));

  // R2
  enter_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovl_active) |-> $past(bus_wr && bus_addr == ADDR_W'(KEY_A1) && bus_wdata == DATA_W'(KEY_D1)));

  // R11
  leave_after_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovl_active) |-> $past(bus_wr && bus_addr == ADDR_W'(EXIT_A) && bus_wdata == DATA_W'(EXIT_D)));

  // R8
  reserved_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_active && bus_rd && (bus_addr >> 2) == 0) |-> reg_rdata[DATA_W-1:10] == '0);

  // R10
  far_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_active && bus_rd && (bus_addr >> 2) > ADDR_W'(PW_WORDS)) |-> reg_rdata == '0);

  // R9
  cfg_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovl_active && bus_wr) |=> ($stable(password) && $stable(ctrl_view)));

endmodule

bind ovl_unlock_top ovl_unlock_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PW_WORDS(PW_WORDS),
  .KEY_A1(KEY_A1), .KEY_D1(KEY_D1), .EXIT_A(EXIT_A), .EXIT_D(EXIT_D)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .mem_wr(mem_wr), .mem_rd(mem_rd),
  .reg_rdata(reg_rdata), .ovl_active(ovl_active), .rd_prot_range(rd_prot_range),
  .wr_prot_range(wr_prot_range), .rd_prot_en(rd_prot_en), .wr_prot_en(wr_prot_en),
  .password(password)
);

// File: tb/sim_ovl_unlock_top.sv
`timescale 1ns/1ps
module sim_ovl_unlock_top;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int PW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [DW-1:0]   bus_wdata = '0;
  logic            mem_wr, mem_rd, ovl_active;
  logic [DW-1:0]   reg_rdata;
  logic [3:0]      rd_prot_range, wr_prot_range;
  logic            rd_prot_en, wr_prot_en;
  logic [PW*DW-1:0] password;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [DW-1:0] pw_m [PW];

  always #2.5 clk = ~clk;

  ovl_unlock_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .reg_rdata(reg_rdata), .ovl_active(ovl_active), .rd_prot_range(rd_prot_range),
    .wr_prot_range(wr_prot_range), .rd_prot_en(rd_prot_en), .wr_prot_en(wr_prot_en),
    .password(password)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, output logic fwd);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #1 fwd = mem_wr;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic fwd);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 begin d = reg_rdata; fwd = mem_rd; end
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic key_step(input int n, output logic fwd);
    if (n == 2) do_wr(32'h2AA, 32'h55, fwd);
    else        do_wr(32'h55, 32'hAA, fwd);
  endtask

  task automatic t_reset;
    check("R1 active", ovl_active, 0);
    check("R1 ctrl", {wr_prot_en, rd_prot_en, wr_prot_range, rd_prot_range}, 0);
    check("R1 password", (password == '0), 1);
  endtask

  task automatic t_enter_and_regs;
    logic f; logic [DW-1:0] d;
    for (int s = 1; s <= 3; s++) begin
      key_step(s, f);
      check("R6 key write held back", f, 0);
    end
    check("R2 overlay open", ovl_active, 1);
    do_rd(32'h1000, d, f);
    check("R7 no mem read", f, 0);
    check("R10 far read zero", d, 0);
    do_wr(32'h0, 32'hFFFF_FFFF, f);
    check("R7 no mem write", f, 0);
    do_rd(32'h0, d, f);
    check("R8 reserved bits zero", d, 32'h3FF);
    check("R8 fields all ones", {wr_prot_en, rd_prot_en, wr_prot_range, rd_prot_range}, 10'h3FF);
    do_wr(32'h2, 32'h0000_0125, f);  // bits [1:0] ignored: slot 0
    do_rd(32'h0, d, f);
    check("R8 ctrl readback", d, 32'h125);
    check("R8 rd range", rd_prot_range, 4'h5);
    check("R8 wr range", wr_prot_range, 4'h2);
    check("R8 rd enable", rd_prot_en, 1);
    check("R8 wr enable", wr_prot_en, 0);
    for (int k = 0; k < PW; k++) begin
      pw_m[k] = 32'hC0DE_0000 | (k * 32'h1111) | 32'h8000_0000;
      do_wr(AW'(4 * (k + 1)), pw_m[k], f);
    end
    for (int k = 0; k < PW; k++) begin
      do_rd(AW'(4 * (k + 1)), d, f);
      check("R9 password readback", d, pw_m[k]);
      check("R9 password port slice", password[k*DW +: DW], pw_m[k]);
    end
    do_wr(32'h24, 32'hDEAD_BEEF, f);
    do_wr(32'h7C, 32'h1234_5678, f);
    do_rd(32'h24, d, f);
    check("R10 slot 9 reads zero", d, 0);
    for (int k = 0; k < PW; k++)
      check("R10 password untouched", password[k*DW +: DW], pw_m[k]);
    do_rd(32'h0, d, f);
    check("R10 ctrl untouched", d, 32'h125);
  endtask

  task automatic t_exit;
    logic f; logic [DW-1:0] d;
    do_wr(32'h5A, 32'hFF, f);
    check("R11 exit not forwarded", f, 0);
    check("R11 overlay closed", ovl_active, 0);
    check("R11 ctrl retained", {wr_prot_en, rd_prot_en, wr_prot_range, rd_prot_range}, 10'h125);
    check("R11 password retained", password[7*DW +: DW], pw_m[7]);
    do_wr(32'h100, 32'h77, f);
    check("R11 normal write forwarded", f, 1);
    do_rd(32'h100, d, f);
    check("R11 normal read forwarded", f, 1);
  endtask

  task automatic t_abort;
    logic f;
    key_step(1, f);
    do_wr(32'h200, 32'h1, f);
    check("R6 plain write forwarded", f, 1);
    key_step(2, f);
    check("R3 step two from idle forwarded", f, 1);
    key_step(3, f);
    check("R3 aborted key stays closed", ovl_active, 0);
    do_wr(32'h204, 32'h2, f);  // clear tracker
  endtask

  task automatic t_restart;
    logic f;
    key_step(1, f);
    key_step(1, f);
    check("R4 repeated step one held back", f, 0);
    key_step(2, f);
    key_step(3, f);
    check("R4 repeat restarts at step two", ovl_active, 1);
    do_wr(32'h5A, 32'hFF, f);
    check("R11 closed again", ovl_active, 0);
  endtask

  task automatic t_reads_between;
    logic f; logic [DW-1:0] d;
    key_step(1, f);
    do_rd(32'h55, d, f);
    key_step(2, f);
    do_rd(32'h300, d, f);
    check("R5 read forwarded mid key", f, 1);
    key_step(3, f);
    check("R5 reads do not break key", ovl_active, 1);
    do_wr(32'h5A, 32'hFF, f);
  endtask

  task automatic t_exit_in_normal;
    logic f;
    do_wr(32'h5A, 32'hFF, f);
    check("R12 exit write forwarded in normal mode", f, 1);
    check("R12 stays closed", ovl_active, 0);
  endtask

  task automatic t_reset_mid;
    logic f;
    for (int s = 1; s <= 3; s++) key_step(s, f);
    check("R2 reopened", ovl_active, 1);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    check("R1 reset closes overlay", ovl_active, 0);
    check("R1 reset clears password", (password == '0), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enter_and_regs();
    t_exit();
    t_abort();
    t_restart();
    t_reads_between();
    t_exit_in_normal();
    t_reset_mid();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule